// File: doc/BRIEF.md
# Load-Store Effective Address Generator

This block forms the memory address for every data access of a 32-bit load-store core with sixteen general registers and a global base register. The decoder gives it an addressing-mode code, an operand size and a displacement field. The register file supplies the base register, register zero, the global base and the current program counter. One cycle later the block returns the effective address, a flag that says whether a data access takes place, and the new base-register value that the auto-increment and auto-decrement modes write back.

The same stage also widens narrow load data to 32 bits. Arithmetic use sign-extends it and logic use zero-extends it. Register-direct, immediate and unused mode codes make no access and return a zero address. The mode that adds a register to the program counter returns a jump target and makes no data access.

Top module: `eag_top`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: All outputs are registered. valid_o equals valid_i from the previous rising edge. When valid_i was low, mem_o, wb_en_o, ea_o, wb_data_o and ext_o are zero in the next cycle.
- R3: Mode 1 (indirect) gives ea = Rn. Mode 5 gives ea = R0 + Rn. Mode 7 gives ea = R0 + GBR. Mode 9 gives ea = PC + Rn as a target with mem_o = 0. All sums wrap modulo 2^32.
- R4: The operand-size code sets the step: 0 = byte (1), 1 = word (2), 2 or 3 = longword (4). Mode 2 (post-increment) gives ea = Rn and writes back Rn + step. Mode 3 (pre-decrement) writes back Rn - step and uses that new value as ea. Both wrap modulo 2^32.
- R5: Mode 4 gives ea = Rn + zero-extended disp_i[3:0] × step, and bits 7:4 of disp_i are ignored. Mode 6 gives ea = GBR + zero-extended disp_i[7:0] × step.
- R6: Mode 8 (PC-relative data) gives ea = PC + disp_i[7:0] × step. For size codes 2 and 3 the two low PC bits are cleared before the add.
- R7: Modes 0 (register direct), 10 (immediate) and the unused codes 11 to 15 give mem_o = 0 and ea_o = 0.
- R8: wb_en_o is high only for valid requests in modes 2 and 3. Otherwise it is low and wb_data_o is zero.
- R9: Size code 0 extends ld_data_i[7:0] and size code 1 extends ld_data_i[15:0]. The extension copies the top data bit when ext_arith_i = 1 and fills with zeros when it is 0. Size codes 2 and 3 pass ld_data_i through unchanged.
- R10: mem_o is high for valid requests in modes 1 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| mode_i | input | 4 | Addressing-mode code |
| size_i | input | 2 | Operand-size code |
| disp_i | input | 8 | Displacement field |
| rn_i | input | 32 | Base register value |
| r0_i | input | 32 | Register zero value |
| gbr_i | input | 32 | Global base register value |
| pc_i | input | 32 | Current program counter |
| ld_data_i | input | 32 | Raw load data to extend |
| ext_arith_i | input | 1 | 1 = sign-extend, 0 = zero-extend |
| valid_o | output | 1 | Registered request valid |
| mem_o | output | 1 | Data access takes place |
| ea_o | output | 32 | Effective address or target |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_data_o | output | 32 | Base register write-back value |
| ext_o | output | 32 | Extended load data |

## Verification
The assertions check on every cycle:
- that valid_o tracks valid_i;
- that write-back appears only with a data access and only in the two auto-modify modes;
- that pre-decrement addresses through its own write-back value;
- that post-increment and indirect addresses equal the prior base register;
- that PC-relative longword addresses are aligned;
- that no-access modes never raise mem_o;
- that zero-extended bytes have clear upper bits.

The exact sums can only be shown by the bench's sweep, which runs every mode code and size code against a bench-side model. That sweep covers scaled displacements, ignored displacement bits, wrap-around at both ends of the address space and the full byte table for both extension classes.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned SIZE_W = 2;

  localparam logic [MODE_W-1:0] M_DIRECT  = 4'd0;
  localparam logic [MODE_W-1:0] M_IND     = 4'd1;
  localparam logic [MODE_W-1:0] M_POSTINC = 4'd2;
  localparam logic [MODE_W-1:0] M_PREDEC  = 4'd3;
  localparam logic [MODE_W-1:0] M_RDISP   = 4'd4;
  localparam logic [MODE_W-1:0] M_RIDX    = 4'd5;
  localparam logic [MODE_W-1:0] M_GDISP   = 4'd6;
  localparam logic [MODE_W-1:0] M_GIDX    = 4'd7;
  localparam logic [MODE_W-1:0] M_PCDISP  = 4'd8;
  localparam logic [MODE_W-1:0] M_PCREG   = 4'd9;
  localparam logic [MODE_W-1:0] M_IMM     = 4'd10;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
  localparam logic [SIZE_W-1:0] SZ_WORD = 2'd1;

  // log2 of the operand step
  function automatic logic [1:0] size_shift(input logic [SIZE_W-1:0] sz);
    case (sz)
      SZ_BYTE: size_shift = 2'd0;
      SZ_WORD: size_shift = 2'd1;
      default: size_shift = 2'd2;
    endcase
  endfunction

  function automatic logic is_mem_mode(input logic [MODE_W-1:0] m);
    is_mem_mode = (m >= M_IND) && (m <= M_PCDISP);
  endfunction

  function automatic logic is_auto_mode(input logic [MODE_W-1:0] m);
    is_auto_mode = (m == M_POSTINC) || (m == M_PREDEC);
  endfunction
endpackage

// File: rtl/eag_offset.sv
module eag_offset
  import eag_pkg::*;
#(
  parameter int unsigned XW  = 32,
  parameter int unsigned DW  = 8,
  parameter int unsigned SDW = 4
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DW-1:0]     disp_i,
  output logic [XW-1:0]     offset_o,
  output logic [XW-1:0]     step_o
);
  localparam int unsigned LPAD = XW - DW;
  localparam int unsigned SPAD = XW - SDW;

  logic [1:0]    sh;
  logic [XW-1:0] disp_long;
  logic [XW-1:0] disp_short;

  assign sh = size_shift(size_i);

  generate
    if (SDW < DW) begin : g_trunc
      assign disp_short = {{SPAD{1'b0}}, disp_i[SDW-1:0]};
    end else begin : g_full
      assign disp_short = {{LPAD{1'b0}}, disp_i};
    end
  endgenerate

  assign disp_long = {{LPAD{1'b0}}, disp_i};

  always_comb begin
    step_o = {{(XW-1){1'b0}}, 1'b1} << sh;
    unique case (mode_i)
      M_RDISP:           offset_o = disp_short << sh;
      M_GDISP, M_PCDISP: offset_o = disp_long << sh;
      default:           offset_o = '0;
    endcase
  end
endmodule

// File: rtl/eag_addr.sv
module eag_addr
  import eag_pkg::*;
#(
  parameter int unsigned XW = 32
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [XW-1:0]     rn_i,
  input  logic [XW-1:0]     r0_i,
  input  logic [XW-1:0]     gbr_i,
  input  logic [XW-1:0]     pc_i,
  input  logic [XW-1:0]     offset_i,
  input  logic [XW-1:0]     step_i,
  output logic [XW-1:0]     ea_o,
  output logic              mem_o,
  output logic              wb_en_o,
  output logic [XW-1:0]     wb_data_o
);
  logic [XW-1:0] pc_base;
  logic [XW-1:0] rn_up;
  logic [XW-1:0] rn_dn;
  logic          long_sz;

  assign long_sz = size_i[1];
  // longword literal fetch aligns PC first
  assign pc_base = long_sz ? {pc_i[XW-1:2], 2'b00} : pc_i;
  assign rn_up   = rn_i + step_i;
  assign rn_dn   = rn_i - step_i;

  always_comb begin
    unique case (mode_i)
      M_IND, M_POSTINC: ea_o = rn_i;
      M_PREDEC:         ea_o = rn_dn;
      M_RDISP:          ea_o = rn_i + offset_i;
      M_RIDX:           ea_o = r0_i + rn_i;
      M_GDISP:          ea_o = gbr_i + offset_i;
      M_GIDX:           ea_o = r0_i + gbr_i;
      M_PCDISP:         ea_o = pc_base + offset_i;
      M_PCREG:          ea_o = pc_i + rn_i;
      default:          ea_o = '0;
    endcase
  end

  always_comb begin
    mem_o   = is_mem_mode(mode_i);
    wb_en_o = is_auto_mode(mode_i);
    unique case (mode_i)
      M_POSTINC: wb_data_o = rn_up;
      M_PREDEC:  wb_data_o = rn_dn;
      default:   wb_data_o = '0;
    endcase
  end
endmodule

// File: rtl/eag_ext.sv
module eag_ext
  import eag_pkg::*;
#(
  parameter int unsigned XW = 32,
  parameter int unsigned BW = 8,
  parameter int unsigned HW = 16
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic              arith_i,
  input  logic [XW-1:0]     data_i,
  output logic [XW-1:0]     data_o
);
  logic [XW-1:0] byte_x;
  logic [XW-1:0] half_x;

  assign byte_x = {{(XW-BW){arith_i & data_i[BW-1]}}, data_i[BW-1:0]};
  assign half_x = {{(XW-HW){arith_i & data_i[HW-1]}}, data_i[HW-1:0]};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = byte_x;
      SZ_WORD: data_o = half_x;
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int unsigned XW  = 32,
  parameter int unsigned DW  = 8,
  parameter int unsigned SDW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [DW-1:0]     disp_i,
  input  logic [XW-1:0]     rn_i,
  input  logic [XW-1:0]     r0_i,
  input  logic [XW-1:0]     gbr_i,
  input  logic [XW-1:0]     pc_i,
  input  logic [XW-1:0]     ld_data_i,
  input  logic              ext_arith_i,
  output logic              valid_o,
  output logic              mem_o,
  output logic [XW-1:0]     ea_o,
  output logic              wb_en_o,
  output logic [XW-1:0]     wb_data_o,
  output logic [XW-1:0]     ext_o
);
  logic [XW-1:0] offset;
  logic [XW-1:0] step;
  logic [XW-1:0] ea_d;
  logic          mem_d;
  logic          wb_en_d;
  logic [XW-1:0] wb_data_d;
  logic [XW-1:0] ext_d;

  eag_offset #(.XW(XW), .DW(DW), .SDW(SDW)) i_offset (
    .mode_i  (mode_i),
    .size_i  (size_i),
    .disp_i  (disp_i),
    .offset_o(offset),
    .step_o  (step)
  );

  eag_addr #(.XW(XW)) i_addr (
    .mode_i   (mode_i),
    .size_i   (size_i),
    .rn_i     (rn_i),
    .r0_i     (r0_i),
    .gbr_i    (gbr_i),
    .pc_i     (pc_i),
    .offset_i (offset),
    .step_i   (step),
    .ea_o     (ea_d),
    .mem_o    (mem_d),
    .wb_en_o  (wb_en_d),
    .wb_data_o(wb_data_d)
  );

  eag_ext #(.XW(XW)) i_ext (
    .size_i (size_i),
    .arith_i(ext_arith_i),
    .data_i (ld_data_i),
    .data_o (ext_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      mem_o     <= 1'b0;
      ea_o      <= '0;
      wb_en_o   <= 1'b0;
      wb_data_o <= '0;
      ext_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        mem_o     <= mem_d;
        ea_o      <= ea_d;
        wb_en_o   <= wb_en_d;
        wb_data_o <= wb_data_d;
        ext_o     <= ext_d;
      end else begin
        mem_o     <= 1'b0;
        ea_o      <= '0;
        wb_en_o   <= 1'b0;
        wb_data_o <= '0;
        ext_o     <= '0;
      end
    end
  end
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int unsigned XW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [3:0]    mode_i,
  input logic [1:0]    size_i,
  input logic [XW-1:0] rn_i,
  input logic          ext_arith_i,
  input logic          valid_o,
  input logic          mem_o,
  input logic [XW-1:0] ea_o,
  input logic          wb_en_o,
  input logic [XW-1:0] wb_data_o,
  input logic [XW-1:0] ext_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !mem_o && !wb_en_o));
  a_r8_wb_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (mem_o && valid_o));
  a_r8_wb_only_auto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != 4'd2 && mode_i != 4'd3) |=> !wb_en_o);
  a_r4_predec_uses_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 4'd3) |=> (wb_en_o && ea_o == wb_data_o));
  a_r4_postinc_uses_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 4'd2) |=> (wb_en_o && ea_o == $past(rn_i)));
  a_r3_indirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 4'd1) |=> (mem_o && ea_o == $past(rn_i)));
  a_r6_pc_long_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 4'd8 && size_i[1]) |=> (ea_o[1:0] == 2'b00));
  a_r7_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (mode_i == 4'd0 || mode_i >= 4'd9)) |=> !mem_o);
  a_r9_byte_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ext_arith_i && size_i == 2'd0) |=> (ext_o[XW-1:8] == '0));
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !mem_o && !wb_en_o));
endmodule

bind eag_top eag_checker #(.XW(XW)) i_eag_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .mode_i     (mode_i),
  .size_i     (size_i),
  .rn_i       (rn_i),
  .ext_arith_i(ext_arith_i),
  .valid_o    (valid_o),
  .mem_o      (mem_o),
  .ea_o       (ea_o),
  .wb_en_o    (wb_en_o),
  .wb_data_o  (wb_data_o),
  .ext_o      (ext_o)
);

// File: tb/test_eag_top.sv
`timescale 1ns/1ps
module test_eag_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic [7:0]  disp_i = '0;
  logic [31:0] rn_i = '0, r0_i = '0, gbr_i = '0, pc_i = '0, ld_data_i = '0;
  logic        ext_arith_i = 1'b0;
  logic        valid_o, mem_o, wb_en_o;
  logic [31:0] ea_o, wb_data_o, ext_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk_i = ~clk_i;

  eag_top i_eag_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .size_i(size_i), .disp_i(disp_i), .rn_i(rn_i), .r0_i(r0_i), .gbr_i(gbr_i),
    .pc_i(pc_i), .ld_data_i(ld_data_i), .ext_arith_i(ext_arith_i),
    .valid_o(valid_o), .mem_o(mem_o), .ea_o(ea_o), .wb_en_o(wb_en_o),
    .wb_data_o(wb_data_o), .ext_o(ext_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic string mode_tag(input logic [3:0] m);
    case (m)
      4'd1, 4'd5, 4'd7, 4'd9: return "R3";
      4'd2, 4'd3:             return "R4";
      4'd4, 4'd6:             return "R5";
      4'd8:                   return "R6";
      default:                return "R7";
    endcase
  endfunction

  // independent model of R3..R8, R10
  task automatic expect_ea(input logic [3:0] m, input logic [1:0] sz, input logic [7:0] d,
                           input logic [31:0] rn, input logic [31:0] r0, input logic [31:0] gb,
                           input logic [31:0] pc, output logic [31:0] ea, output logic mem,
                           output logic wbe, output logic [31:0] wbd);
    logic [31:0] sc;
    sc = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    ea = 32'd0; mem = 1'b0; wbe = 1'b0; wbd = 32'd0;
    case (m)
      4'd1: begin ea = rn; mem = 1'b1; end
      4'd2: begin ea = rn; mem = 1'b1; wbe = 1'b1; wbd = rn + sc; end
      4'd3: begin wbd = rn - sc; ea = wbd; mem = 1'b1; wbe = 1'b1; end
      4'd4: begin ea = rn + {28'd0, d[3:0]} * sc; mem = 1'b1; end
      4'd5: begin ea = r0 + rn; mem = 1'b1; end
      4'd6: begin ea = gb + {24'd0, d} * sc; mem = 1'b1; end
      4'd7: begin ea = r0 + gb; mem = 1'b1; end
      4'd8: begin
        ea = (sz >= 2'd2) ? ((pc / 32'd4) * 32'd4) : pc;
        ea = ea + {24'd0, d} * sc;
        mem = 1'b1;
      end
      4'd9: ea = pc + rn;
      default: ;
    endcase
  endtask

  task automatic run_vec(input logic [3:0] m, input logic [1:0] sz, input logic [7:0] d,
                         input logic [31:0] rn, input logic [31:0] r0, input logic [31:0] gb,
                         input logic [31:0] pc);
    logic [31:0] e_ea, e_wbd;
    logic e_mem, e_wbe;
    string t;
    valid_i = 1'b1; mode_i = m; size_i = sz; disp_i = d;
    rn_i = rn; r0_i = r0; gbr_i = gb; pc_i = pc;
    expect_ea(m, sz, d, rn, r0, gb, pc, e_ea, e_mem, e_wbe, e_wbd);
    t = mode_tag(m);
    @(negedge clk_i);
    chk({"R2 valid m", t}, {31'd0, valid_o}, 32'd1);
    chk({t, " ea"}, ea_o, e_ea);
    chk({"R10 mem ", t}, {31'd0, mem_o}, {31'd0, e_mem});
    chk({"R8 wb_en ", t}, {31'd0, wb_en_o}, {31'd0, e_wbe});
    chk({"R8 wb_data ", t}, wb_data_o, e_wbd);
  endtask

  task automatic run_ext(input logic [1:0] sz, input logic ar, input logic [31:0] d);
    logic [31:0] e;
    valid_i = 1'b1; mode_i = 4'd0; size_i = sz; ext_arith_i = ar; ld_data_i = d;
    if (sz == 2'd0)      e = (ar && d[7])  ? (32'hFFFF_FF00 | {24'd0, d[7:0]})  : {24'd0, d[7:0]};
    else if (sz == 2'd1) e = (ar && d[15]) ? (32'hFFFF_0000 | {16'd0, d[15:0]}) : {16'd0, d[15:0]};
    else                 e = d;
    @(negedge clk_i);
    chk("R9 extend", ext_o, e);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", {31'd0, valid_o}, 32'd0);
    chk("R1 reset ea", ea_o, 32'd0);
    chk("R1 reset wb", wb_data_o | {31'd0, wb_en_o | mem_o}, 32'd0);
    chk("R1 reset ext", ext_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep every mode and size code with assorted operands
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 8; k++) begin
          logic [7:0] d;
          d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h0F : (k == 3) ? 8'hF0 : rnd();
          run_vec(4'(m), 2'(s), d, rnd(), rnd(), rnd(), rnd());
        end
      end
    end

    // wrap-around and alignment corners
    run_vec(4'd3, 2'd2, 8'h00, 32'h0000_0000, 0, 0, 0);           // R4 predec wraps to FFFF_FFFC
    run_vec(4'd2, 2'd2, 8'h00, 32'hFFFF_FFFE, 0, 0, 0);           // R4 postinc wraps to 2
    run_vec(4'd3, 2'd0, 8'h00, 32'h0000_0000, 0, 0, 0);           // R4 byte step
    run_vec(4'd8, 2'd2, 8'hFF, 0, 0, 0, 32'h0000_1003);           // R6 aligned long
    run_vec(4'd8, 2'd1, 8'h01, 0, 0, 0, 32'h0000_1003);           // R6 word keeps low bits
    run_vec(4'd4, 2'd2, 8'hF3, 32'h100, 0, 0, 0);                 // R5 upper disp ignored
    run_vec(4'd6, 2'd1, 8'h80, 0, 0, 32'hFFFF_FF00, 0);           // R5 gbr disp wraps
    run_vec(4'd7, 2'd0, 8'h00, 0, 32'hFFFF_FFFF, 32'd2, 0);       // R3 indexed wrap

    // R2: idle request leaves nothing behind
    valid_i = 1'b0; mode_i = 4'd2; rn_i = 32'h55;
    @(negedge clk_i);
    chk("R2 idle valid", {31'd0, valid_o}, 32'd0);
    chk("R2 idle ea", ea_o, 32'd0);
    chk("R8 idle wb_en", {31'd0, wb_en_o}, 32'd0);
    chk("R2 idle mem", {31'd0, mem_o}, 32'd0);

    // R9: full byte table, both classes; word and long samples
    for (int b = 0; b < 256; b++) begin
      run_ext(2'd0, 1'b0, {rnd() & 32'hFFFF_FF00} | 32'(b));
      run_ext(2'd0, 1'b1, {rnd() & 32'hFFFF_FF00} | 32'(b));
    end
    for (int k = 0; k < 64; k++) begin
      run_ext(2'd1, k[0], rnd());
      run_ext(2'(2 + k[1]), k[0], rnd());
    end
    run_ext(2'd1, 1'b1, 32'h0000_8000);
    run_ext(2'd1, 1'b0, 32'hFFFF_7FFF);

    // R1: asynchronous reset mid-run
    valid_i = 1'b1; mode_i = 4'd2; rn_i = 32'h40;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset valid", {31'd0, valid_o}, 32'd0);
    chk("R1 async reset wb_en", {31'd0, wb_en_o}, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule